// File: doc/BRIEF.md
# Interrupt Gate Descriptor Dispatcher

This block turns an interrupt vector into a handler entry point. A request carries the vector, the kind of event that raised it (software instruction, external hardware line or processor exception) and the privilege level of the running code. The dispatcher looks up the 8-byte entry for that vector in a descriptor table. The table's base address and byte limit are supplied by a loadable table register. The entry arrives as two 32-bit words over a simple read port.

After the fetch, the block validates the descriptor and returns one of three results. A direct jump gives a target selector, a 32-bit offset and the new interrupt-enable flag. A task-switch request gives the task selector. A protection fault gives a fault vector and an error code that names the offending vector.

Interrupt gates clear the interrupt-enable flag and trap gates keep it. Task gates only forward their selector, because the switch itself happens elsewhere. The privilege rules applied are:
- the gate's own privilege, checked against the caller only for software events;
- the present bit;
- a ban on moving control to a less privileged target.

Top module: `gate_dispatch`

## Requirements
- R1: After reset, `reqReady` is 1, and both `resValid` and `rdValid` are 0.
- R2: A request is taken when `reqValid` and `reqReady` are both 1. `reqReady` is 0 from acceptance until the result has been shown. Every accepted request yields exactly one result.
- R3: The low descriptor word is read from `tableBase + 8*vector`, then the high word from that address plus 4, in that order. While `rdValid` is 1 and `rdReady` is 0, `rdAddr` holds steady. Read data is taken in the cycle where both are 1.
- R4: If `8*vector+7 > tableLimit`, the result is a fault with vector 13, and no read is issued.
- R5: Field layout. Low word [15:0] is offset[15:0] and low word [31:16] is the selector. High word [31:16] is offset[31:16]. High word [15:8] is the attribute byte: bit 7 is present, bits 6:5 are the gate privilege, bits 4:0 are the type. Type 0x0E is an interrupt gate, 0x0F a trap gate and 0x05 a task gate.
- R6: A valid interrupt gate gives `resKind`=0 (jump), the selector, the full offset and `resIf`=0.
- R7: A valid trap gate gives `resKind`=0 with `resIf` equal to the `curIf` sampled with the request.
- R8: A valid task gate gives `resKind`=1, the selector, offset 0 and `resIf`=`curIf`. The target privilege rule of R11 is not applied to task gates.
- R9: For software requests (`reqSrc`=0), a caller privilege numerically greater than the gate privilege gives fault 13. Hardware (`reqSrc`=1) and exception (`reqSrc`=2 or 3) requests skip this test.
- R10: A descriptor with the present bit clear gives fault 11.
- R11: For interrupt and trap gates, the target privilege is taken from selector bits [1:0]. If it is numerically greater than the caller privilege, the result is fault 13.
- R12: Any other type value gives fault 13. The checks run in this order: limit, type, gate privilege, present, target privilege. The first one that fails decides the result.
- R13: A fault gives `resKind`=2, with selector and offset both 0 and `resIf`=`curIf`. The error code is `vector*8 + 2`, plus 1 when the request is not software.
- R14: `resValid` is high for exactly one cycle per result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Dispatcher idle, request accepted this cycle if offered |
| reqVector | input | VEC_W | Interrupt vector |
| reqSrc | input | 2 | 0 software, 1 hardware, 2/3 exception |
| reqCpl | input | 2 | Caller privilege level |
| curIf | input | 1 | Current interrupt-enable flag |
| tableBase | input | ADDR_W | Linear base of the descriptor table |
| tableLimit | input | LIMIT_W | Last valid byte offset of the table |
| rdValid | output | 1 | Read request |
| rdReady | input | 1 | Read completes, data valid this cycle |
| rdAddr | output | ADDR_W | Read byte address |
| rdData | input | 32 | Read data |
| resValid | output | 1 | Result strobe (one cycle) |
| resKind | output | 2 | 0 jump, 1 task switch, 2 fault |
| resSelector | output | 16 | Target selector |
| resOffset | output | 32 | Target offset |
| resIf | output | 1 | New interrupt-enable flag |
| resFaultVec | output | 8 | Fault vector (11 or 13), 0 otherwise |
| resErrCode | output | 16 | Fault error code, 0 otherwise |

## Verification
The bench builds the block with its default widths: an 8-bit vector, a 16-bit limit and 32-bit addresses. The table limit is set to cover 201 entries. It then sweeps every vector against every caller privilege and every source kind. The descriptor for each vector is computed arithmetically from the vector number, so the full matrix of gate types, privilege pairs and present bits is covered. The 55 vectors beyond the limit give the out-of-table case. Further runs place the limit exactly one byte short of an entry and exactly on its last byte. An irregular read-ready pattern keeps the address-hold and read-order rules in play.

// File: rtl/gate_pkg.sv
package gate_pkg;
  localparam int WORD_W = 32;
  localparam int SEL_W  = 16;
  localparam int OFF_W  = 32;

  localparam logic [1:0] KIND_JUMP  = 2'd0;
  localparam logic [1:0] KIND_TASK  = 2'd1;
  localparam logic [1:0] KIND_FAULT = 2'd2;

  localparam logic [1:0] SRC_SOFT = 2'd0;

  localparam logic [4:0] TYPE_TASK = 5'h05;
  localparam logic [4:0] TYPE_INTR = 5'h0E;
  localparam logic [4:0] TYPE_TRAP = 5'h0F;

  localparam logic [7:0] FVEC_NOT_PRESENT = 8'd11;
  localparam logic [7:0] FVEC_PROTECTION  = 8'd13;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LIMIT, ST_RDLO, ST_RDHI, ST_EVAL, ST_DONE
  } ctlState_t;

  typedef struct packed {
    logic latchReq;
    logic addrHi;
    logic loadLo;
    logic loadHi;
    logic loadRes;
  } dpStrobe_t;
endpackage

// File: rtl/gate_ctl.sv
module gate_ctl
  import gate_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      rdReady,
  input  logic      overLimit,
  output logic      reqReady,
  output logic      rdValid,
  output logic      resValid,
  output dpStrobe_t strobe
);
  ctlState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    rdValid   = 1'b0;
    reqReady  = 1'b0;
    resValid  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.latchReq = 1'b1;
          stateNext       = ST_LIMIT;
        end
      end
      ST_LIMIT: begin
        if (overLimit) begin
          strobe.loadRes = 1'b1;
          stateNext      = ST_DONE;
        end else begin
          stateNext = ST_RDLO;
        end
      end
      ST_RDLO: begin
        rdValid       = 1'b1;
        strobe.loadLo = rdReady;
        if (rdReady) stateNext = ST_RDHI;
      end
      ST_RDHI: begin
        rdValid       = 1'b1;
        strobe.addrHi = 1'b1;
        strobe.loadHi = rdReady;
        if (rdReady) stateNext = ST_EVAL;
      end
      ST_EVAL: begin
        strobe.loadRes = 1'b1;
        stateNext      = ST_DONE;
      end
      ST_DONE: begin
        resValid  = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/gate_dp.sv
module gate_dp
  import gate_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LIMIT_W = 16,
  parameter int VEC_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [VEC_W-1:0]    reqVector,
  input  logic [1:0]          reqSrc,
  input  logic [1:0]          reqCpl,
  input  logic                curIf,
  input  logic [ADDR_W-1:0]   tableBase,
  input  logic [LIMIT_W-1:0]  tableLimit,
  input  logic [WORD_W-1:0]   rdData,
  output logic [ADDR_W-1:0]   rdAddr,
  output logic                overLimit,
  output logic [1:0]          resKind,
  output logic [SEL_W-1:0]    resSelector,
  output logic [OFF_W-1:0]    resOffset,
  output logic                resIf,
  output logic [7:0]          resFaultVec,
  output logic [SEL_W-1:0]    resErrCode
);
  localparam int CMP_W = VEC_W + 3 + LIMIT_W;

  logic [VEC_W-1:0] vecQ;
  logic [1:0]       srcQ;
  logic [1:0]       cplQ;
  logic             ifQ;
  logic [15:0]      offLoQ;
  logic [SEL_W-1:0] selQ;
  logic [7:0]       attrQ;
  logic [15:0]      offHiQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecQ <= '0;
      srcQ <= '0;
      cplQ <= '0;
      ifQ  <= 1'b0;
    end else if (strobe.latchReq) begin
      vecQ <= reqVector;
      srcQ <= reqSrc;
      cplQ <= reqCpl;
      ifQ  <= curIf;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offLoQ <= '0;
      selQ   <= '0;
      attrQ  <= '0;
      offHiQ <= '0;
    end else begin
      if (strobe.loadLo) begin
        offLoQ <= rdData[15:0];
        selQ   <= rdData[31:16];
      end
      if (strobe.loadHi) begin
        attrQ  <= rdData[15:8];
        offHiQ <= rdData[31:16];
      end
    end
  end

  logic [CMP_W-1:0]  entryEnd;
  logic [ADDR_W-1:0] entryAddr;

  always_comb begin
    entryEnd  = CMP_W'({vecQ, 3'b111});
    overLimit = entryEnd > CMP_W'(tableLimit);
    entryAddr = tableBase + ADDR_W'({vecQ, 3'b000});
    rdAddr    = strobe.addrHi ? entryAddr + ADDR_W'(4) : entryAddr;
  end

  logic       gPresent;
  logic [1:0] gDpl;
  logic [4:0] gType;
  logic       isIntr, isTrap, isTask, typeOk, softDenied, targetDenied;

  always_comb begin
    gPresent     = attrQ[7];
    gDpl         = attrQ[6:5];
    gType        = attrQ[4:0];
    isIntr       = gType == TYPE_INTR;
    isTrap       = gType == TYPE_TRAP;
    isTask       = gType == TYPE_TASK;
    typeOk       = isIntr | isTrap | isTask;
    softDenied   = (srcQ == SRC_SOFT) && (cplQ > gDpl);
    targetDenied = !isTask && (selQ[1:0] > cplQ);
  end

  logic [1:0]       nKind;
  logic [SEL_W-1:0] nSel;
  logic [OFF_W-1:0] nOff;
  logic             nIf;
  logic [7:0]       nFvec;
  logic [SEL_W-1:0] nErr;
  logic [SEL_W-1:0] faultErr;

  always_comb begin
    faultErr = SEL_W'({vecQ, 3'b000}) | SEL_W'(2) | SEL_W'(srcQ != SRC_SOFT);
    nKind = KIND_FAULT;
    nSel  = '0;
    nOff  = '0;
    nIf   = ifQ;
    nFvec = FVEC_PROTECTION;
    nErr  = faultErr;
    if (overLimit || !typeOk || softDenied) begin
      nFvec = FVEC_PROTECTION;
    end else if (!gPresent) begin
      nFvec = FVEC_NOT_PRESENT;
    end else if (targetDenied) begin
      nFvec = FVEC_PROTECTION;
    end else begin
      nFvec = '0;
      nErr  = '0;
      nSel  = selQ;
      if (isTask) begin
        nKind = KIND_TASK;
      end else begin
        nKind = KIND_JUMP;
        nOff  = {offHiQ, offLoQ};
        nIf   = isTrap ? ifQ : 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resKind     <= KIND_JUMP;
      resSelector <= '0;
      resOffset   <= '0;
      resIf       <= 1'b0;
      resFaultVec <= '0;
      resErrCode  <= '0;
    end else if (strobe.loadRes) begin
      resKind     <= nKind;
      resSelector <= nSel;
      resOffset   <= nOff;
      resIf       <= nIf;
      resFaultVec <= nFvec;
      resErrCode  <= nErr;
    end
  end
endmodule

// File: rtl/gate_dispatch.sv
module gate_dispatch
  import gate_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LIMIT_W = 16,
  parameter int VEC_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [VEC_W-1:0]   reqVector,
  input  logic [1:0]         reqSrc,
  input  logic [1:0]         reqCpl,
  input  logic               curIf,
  input  logic [ADDR_W-1:0]  tableBase,
  input  logic [LIMIT_W-1:0] tableLimit,
  output logic               rdValid,
  input  logic               rdReady,
  output logic [ADDR_W-1:0]  rdAddr,
  input  logic [31:0]        rdData,
  output logic               resValid,
  output logic [1:0]         resKind,
  output logic [15:0]        resSelector,
  output logic [31:0]        resOffset,
  output logic               resIf,
  output logic [7:0]         resFaultVec,
  output logic [15:0]        resErrCode
);
  dpStrobe_t strobe;
  logic      overLimit;

  gate_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .rdReady  (rdReady),
    .overLimit(overLimit),
    .reqReady (reqReady),
    .rdValid  (rdValid),
    .resValid (resValid),
    .strobe   (strobe)
  );

  gate_dp #(
    .ADDR_W (ADDR_W),
    .LIMIT_W(LIMIT_W),
    .VEC_W  (VEC_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqVector  (reqVector),
    .reqSrc     (reqSrc),
    .reqCpl     (reqCpl),
    .curIf      (curIf),
    .tableBase  (tableBase),
    .tableLimit (tableLimit),
    .rdData     (rdData),
    .rdAddr     (rdAddr),
    .overLimit  (overLimit),
    .resKind    (resKind),
    .resSelector(resSelector),
    .resOffset  (resOffset),
    .resIf      (resIf),
    .resFaultVec(resFaultVec),
    .resErrCode (resErrCode)
  );
endmodule

// File: rtl/gate_dispatch_chk.sv
module gate_dispatch_chk #(
  parameter int ADDR_W  = 32,
  parameter int LIMIT_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic               reqReady,
  input logic               curIf,
  input logic [ADDR_W-1:0]  tableBase,
  input logic [LIMIT_W-1:0] tableLimit,
  input logic               rdValid,
  input logic               rdReady,
  input logic [ADDR_W-1:0]  rdAddr,
  input logic               resValid,
  input logic [1:0]         resKind,
  input logic [15:0]        resSelector,
  input logic [31:0]        resOffset,
  input logic               resIf,
  input logic [7:0]         resFaultVec,
  input logic [15:0]        resErrCode
);
  logic ifHeld;
  logic pending;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ifHeld  <= 1'b0;
      pending <= 1'b0;
    end else begin
      if (reqValid && reqReady) begin
        ifHeld  <= curIf;
        pending <= 1'b1;
      end else if (resValid) begin
        pending <= 1'b0;
      end
    end
  end

  logic [ADDR_W:0] rdRel;
  always_comb rdRel = {1'b0, rdAddr - tableBase} + (ADDR_W+1)'(3);

  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid); // R14
  AST_RESULT_OWED: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> pending); // R2
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !pending); // R2
  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !rdValid); // R2
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdReady) |=> (rdValid && $stable(rdAddr))); // R3
  AST_READ_IN_TABLE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (rdRel <= (ADDR_W+1)'(tableLimit))); // R4
  AST_IF_NOT_RAISED: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !ifHeld) |-> !resIf); // R6
  AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resKind == 2'd2) |-> (resSelector == 16'd0 && resOffset == 32'd0
                                       && resErrCode[1] && resIf == ifHeld)); // R13
  AST_FAULT_VECTOR: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resKind == 2'd2) |-> (resFaultVec == 8'd11 || resFaultVec == 8'd13)); // R10
  AST_TASK_NO_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resKind == 2'd1) |-> (resOffset == 32'd0 && resIf == ifHeld)); // R8
endmodule

bind gate_dispatch gate_dispatch_chk #(.ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W)) u_chk (.*);

// File: tb/gate_dispatch_bench.sv
`timescale 1ns/1ps
module gate_dispatch_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [7:0]  reqVector = '0;
  logic [1:0]  reqSrc = '0;
  logic [1:0]  reqCpl = '0;
  logic        curIf = 1'b0;
  logic [31:0] tableBase = 32'h0001_0000;
  logic [15:0] tableLimit = 16'd1607;
  logic        rdValid;
  logic        rdReady = 1'b0;
  logic [31:0] rdAddr;
  logic [31:0] rdData;
  logic        resValid;
  logic [1:0]  resKind;
  logic [15:0] resSelector;
  logic [31:0] resOffset;
  logic        resIf;
  logic [7:0]  resFaultVec;
  logic [15:0] resErrCode;

  int compared = 0;
  int mismatched = 0;
  int rdCount = 0;
  logic [31:0] rdAddrSeen [2];
  logic summaryDone = 1'b0;

  always #2 clk = ~clk;

  gate_dispatch u_gate_dispatch (.*);

  function automatic logic [63:0] descOf(input int v);
    logic [7:0]  b;
    logic [15:0] offLo, offHi, sel;
    logic [4:0]  typ;
    logic        pres;
    logic [7:0]  attr;
    b     = v[7:0];
    offLo = {~b, b};
    offHi = {b, 8'hC3};
    sel   = {b ^ 8'h5A, 6'b0, b[1:0] ^ b[7:6]};
    case (b[4:2])
      3'd0, 3'd1, 3'd4, 3'd7: typ = 5'h0E;
      3'd2, 3'd5:             typ = 5'h0F;
      3'd3:                   typ = 5'h05;
      default:                typ = 5'h0C;
    endcase
    pres = (v % 7) != 3;
    attr = {pres, b[6:5], typ};
    return {offHi, attr, 8'h00, sel, offLo};
  endfunction

  assign rdData = ((rdAddr - tableBase) & 32'h4) != 0
                  ? descOf(int'((rdAddr - tableBase) >> 3))[63:32]
                  : descOf(int'((rdAddr - tableBase) >> 3))[31:0];

  always @(posedge clk) begin
    if (rdValid && rdReady) begin
      if (rdCount < 2) rdAddrSeen[rdCount] <= rdAddr;
      rdCount <= rdCount + 1;
    end
  end

  initial begin
    int s;
    s = 0;
    forever begin
      @(negedge clk);
      s = s + 1;
      rdReady = (s % 5 != 1) && (s % 7 != 4);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  task automatic runOne(input int v, input int src, input int cpl, input bit ifIn);
    logic [63:0] d;
    logic [1:0]  eKind;
    logic [15:0] eSel, eErr;
    logic [31:0] eOff;
    logic        eIf;
    logic [7:0]  eFv;
    logic [4:0]  typ;
    logic [1:0]  dpl;
    bit          over, seen;
    string       tag;
    d   = descOf(v);
    typ = d[44:40];
    dpl = d[46:45];
    over = (8*v + 7) > int'(tableLimit);
    eKind = 2'd2; eSel = '0; eOff = '0; eIf = ifIn; eFv = 8'd13;
    eErr = 16'(v*8 + 2 + ((src != 0) ? 1 : 0));
    if (over) tag = "R4";
    else if (typ != 5'h0E && typ != 5'h0F && typ != 5'h05) tag = "R12";
    else if (src == 0 && cpl > int'(dpl)) tag = "R9";
    else if (!d[47]) begin tag = "R10"; eFv = 8'd11; end
    else if (typ != 5'h05 && int'(d[17:16]) > cpl) tag = "R11";
    else begin
      eFv = '0; eErr = '0; eSel = d[31:16];
      if (typ == 5'h05) begin tag = "R8"; eKind = 2'd1; end
      else begin
        eKind = 2'd0; eOff = {d[63:48], d[15:0]};
        if (typ == 5'h0E) begin tag = "R6"; eIf = 1'b0; end
        else tag = "R7";
      end
    end

    @(negedge clk);
    check(reqReady == 1'b1, "R2", "ready before request", reqReady, 1);
    rdCount = 0;
    reqVector = 8'(v); reqSrc = 2'(src); reqCpl = 2'(cpl); curIf = ifIn;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(reqReady == 1'b0, "R2", "ready while busy", reqReady, 0);
    seen = 0;
    for (int t = 0; t < 60 && !seen; t++) begin
      if (resValid) seen = 1;
      else @(negedge clk);
    end
    check(seen, "R2", "result arrived", seen, 1);
    if (seen) begin
      check(resKind == eKind, tag, "kind", resKind, eKind);
      check(resSelector == eSel, tag, "selector", resSelector, eSel);
      check(resOffset == eOff, tag, "offset", resOffset, eOff);
      check(resIf == eIf, tag, "if flag", resIf, eIf);
      check(resFaultVec == eFv, tag, "fault vector", resFaultVec, eFv);
      check(resErrCode == eErr, "R13", "error code", resErrCode, eErr);
      if (over) check(rdCount == 0, "R4", "reads on limit fault", rdCount, 0);
      else begin
        check(rdCount == 2, "R3", "read count", rdCount, 2);
        check(rdAddrSeen[0] == tableBase + 32'(8*v), "R3", "low word addr",
              rdAddrSeen[0], tableBase + 32'(8*v));
        check(rdAddrSeen[1] == tableBase + 32'(8*v + 4), "R3", "high word addr",
              rdAddrSeen[1], tableBase + 32'(8*v + 4));
      end
      @(negedge clk);
      check(resValid == 1'b0, "R14", "result pulse width", resValid, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual expired expected finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(reqReady == 1'b1, "R1", "reqReady in reset", reqReady, 1);
    check(resValid == 1'b0, "R1", "resValid in reset", resValid, 0);
    check(rdValid == 1'b0, "R1", "rdValid in reset", rdValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1 && !resValid && !rdValid, "R1", "idle after reset",
          {reqReady, resValid, rdValid}, 3'b100);

    // Full sweep: limit covers vectors 0..200 (R5 layout used by descOf)
    for (int v = 0; v < 256; v++)
      for (int src = 0; src < 3; src++)
        for (int cpl = 0; cpl < 4; cpl++)
          runOne(v, src, cpl, bit'((v ^ cpl) & 1));

    // Limit boundary: one byte short, then exact (R4)
    tableBase  = 32'h0020_0040;
    tableLimit = 16'(8*50 + 6);
    runOne(50, 1, 0, 1'b1);
    runOne(49, 1, 0, 1'b1);
    tableLimit = 16'(8*50 + 7);
    runOne(50, 1, 0, 1'b1);
    runOne(51, 2, 0, 1'b0);
    tableLimit = 16'hFFFF;
    for (int v = 248; v < 256; v++) runOne(v, 1, 0, 1'b1);

    finishRun();
  end
endmodule